// File: doc/BRIEF.md
# Training Address Auto-Update Unit

This unit keeps the running DRAM address for one subsequence of a memory-training command engine. The address is a 16-bit row/column field, a 3-bit bank and a 2-bit rank, held inside one 26-bit address word. When a subsequence begins, the sequencer pulses `seq_start`. The unit then takes the start address, a 23-bit scrambler seed and a 16-bit update control word. Every command the sequencer issues is reported on `cmd_fire`. After every N+1 commands, the unit updates the address. The update is either a set of fixed increments or one step of a 23-bit LFSR whose bits are XORed into a low window of the address word.

The address presented on the `cur_*` outputs is the address for the next command. When the sequencer pulses `seq_end`, the unit reports the final address and scrambler state for one cycle on the `wb_*` outputs.

The control inputs are plain strobes. The unit applies no back-pressure: it accepts a command on every cycle that `cmd_fire` is high. The `wb_valid` pulse is not held for a consumer, so a consumer must capture the `wb_*` values in the cycle that `wb_valid` is high.

Top module: `addr_autoupd`

## Requirements
- R1: A cycle with `seq_start` high loads the row, bank and rank, the scrambler seed and the control word, and clears the command count. The loaded address appears on `cur_*` after that clock edge.
- R2: With the rate field N in control bits 15..12, the address changes on the (N+1)-th command after the start or after the last update. Every other command leaves it unchanged.
- R3: In increment mode, control bit 0 adds 1 to row/column and bit 1 adds 8 (both together add 9). Bit 2 adds 1 to the bank, and bits 4..3 add 0 to 3 to the rank. Each field wraps modulo its own width, and no carry passes from one field to another.
- R4: The wrap field w in control bits 9..5 limits an update to address word bits w..0. The word has row/column at bits 15..0, bank at 22..20 and rank at 25..24. Bits above w keep their value, and carries out of bit w are dropped.
- R5: Scrambler mode 2 (control bits 11..10 = 10) advances the state once per update as next = {s[21:0], s[22]^s[17]}. The address word bits w..0 are XORed with the same bit positions of the new state, and the increments are not applied.
- R6: Scrambler mode 3 (bits 11..10 = 11) behaves like mode 2, but the XOR window is w..3, so address bits 2..0 are unchanged.
- R7: Modes 0 and 1 use increments and leave the scrambler state unchanged.
- R8: `seq_end` produces `wb_valid` one cycle later for exactly one cycle. The `wb_*` values include any update made by a command in the same cycle as `seq_end`.
- R9: When `seq_start` coincides with `seq_end` and `cmd_fire`, the writeback reports the outgoing subsequence (including that command's update). The new subsequence is loaded with that command not counted.
- R10: After reset, the address, scrambler state and command count are zero, and `wb_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_start | input | 1 | Subsequence begins; load start values |
| start_row | input | 16 | Start row/column address |
| start_bank | input | 3 | Start bank |
| start_rank | input | 2 | Start rank |
| start_lfsr | input | 23 | Scrambler seed |
| upd_ctrl | input | 16 | Update control word, sampled at start |
| cmd_fire | input | 1 | One command issued this cycle |
| seq_end | input | 1 | Subsequence finished; request writeback |
| cur_row | output | 16 | Row/column for the next command |
| cur_bank | output | 3 | Bank for the next command |
| cur_rank | output | 2 | Rank for the next command |
| wb_valid | output | 1 | Writeback values valid (one-cycle pulse) |
| wb_row | output | 16 | Final row/column |
| wb_bank | output | 3 | Final bank |
| wb_rank | output | 2 | Final rank |
| wb_lfsr | output | 23 | Final scrambler state |

## Verification
The hardest situation to reach is the boundary between two subsequences. In that cycle, a command, a finish and a new start land together. The writeback must then carry the outgoing subsequence's last update while the new start discards that command. The bench drives all three strobes in one cycle and checks both the writeback pulse and the freshly loaded address. It also restarts a subsequence partway through a slow update rate, to show that the command count does not leak across the start. The bench checks a wrap window that cuts through the bank field and a scrambler window that skips the low three bits, using seeds whose next state is worked out by hand.

// File: rtl/addr_upd_pkg.sv
package addr_upd_pkg;
  parameter int ROW_W    = 16;
  parameter int BANK_W   = 3;
  parameter int RANK_W   = 2;
  parameter int LFSR_W   = 23;
  parameter int LFSR_TAP = 18;
  parameter int RATE_W   = 4;
  parameter int WRAP_W   = 5;

  localparam int BANK_LSB  = 20;
  localparam int RANK_LSB  = 24;
  localparam int WORD_W    = RANK_LSB + RANK_W;
  localparam int STEP8_BIT = 3;
  localparam int SKIP_LOW  = 3;

  typedef enum logic [1:0] {
    LM_OFF   = 2'b00,
    LM_RSVD  = 2'b01,
    LM_FULL  = 2'b10,
    LM_SKIP3 = 2'b11
  } lfsr_mode_e;

  // Field order follows the control word, MSB first (bits 15..0).
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    lfsr_mode_e        lmode;
    logic [WRAP_W-1:0] wrap;
    logic [1:0]        rank_inc;
    logic              bank_inc;
    logic              row_inc8;
    logic              row_inc1;
  } upd_ctrl_t;

  localparam int CTRL_W = $bits(upd_ctrl_t);
endpackage

// File: rtl/upd_rate_ctr.sv
module upd_rate_ctr #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fire,
  input  logic [RATE_W-1:0] rate,
  output logic              due
);
  logic [RATE_W-1:0] cnt_q;

  assign due = fire && (cnt_q == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (due)    cnt_q <= '0;
    else if (fire)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/upd_lfsr_step.sv
module upd_lfsr_step #(
  parameter int W   = 23,
  parameter int TAP = 18
) (
  input  logic [W-1:0] state,
  output logic [W-1:0] next
);
  // Polynomial x^W + x^TAP + 1, shifting toward the MSB.
  assign next = {state[W-2:0], state[W-1] ^ state[TAP-1]};
endmodule

// File: rtl/upd_addr_calc.sv
module upd_addr_calc
  import addr_upd_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  upd_ctrl_t         ctrl,
  input  logic [LFSR_W-1:0] lfsr_nx,
  output logic [WORD_W-1:0] word_nx
);
  localparam logic [WORD_W-1:0] FIELD_MASK =
      WORD_W'((64'd1 << ROW_W) - 64'd1) |
      (WORD_W'((64'd1 << BANK_W) - 64'd1) << BANK_LSB) |
      (WORD_W'((64'd1 << RANK_W) - 64'd1) << RANK_LSB);

  logic [63:0]               win_wide;
  logic [WORD_W-1:0]         win, lwin, delta, sum, inc_word, lfsr_word;
  logic [WORD_W+LFSR_W-1:0]  lfsr_ext;

  always_comb begin
    win_wide = (64'd2 << ctrl.wrap) - 64'd1;
    win      = win_wide[WORD_W-1:0];
    lwin     = (ctrl.lmode == LM_SKIP3) ? (win & ~WORD_W'((1 << SKIP_LOW) - 1)) : win;

    delta                         = '0;
    delta[0]                      = ctrl.row_inc1;
    delta[STEP8_BIT]              = ctrl.row_inc8;
    delta[BANK_LSB]               = ctrl.bank_inc;
    delta[RANK_LSB +: RANK_W]     = ctrl.rank_inc;

    // Gap bits are zero, so a field carry stops in its gap.
    sum      = word + delta;
    inc_word = ((word & ~win) | (sum & win)) & FIELD_MASK;

    lfsr_ext  = {{WORD_W{1'b0}}, lfsr_nx};
    lfsr_word = (word ^ (lfsr_ext[WORD_W-1:0] & lwin)) & FIELD_MASK;

    word_nx = ctrl.lmode[1] ? lfsr_word : inc_word;
  end
endmodule

// File: rtl/addr_autoupd.sv
module addr_autoupd
  import addr_upd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_start,
  input  logic [15:0]       start_row,
  input  logic [2:0]        start_bank,
  input  logic [1:0]        start_rank,
  input  logic [22:0]       start_lfsr,
  input  logic [15:0]       upd_ctrl,
  input  logic              cmd_fire,
  input  logic              seq_end,
  output logic [15:0]       cur_row,
  output logic [2:0]        cur_bank,
  output logic [1:0]        cur_rank,
  output logic              wb_valid,
  output logic [15:0]       wb_row,
  output logic [2:0]        wb_bank,
  output logic [1:0]        wb_rank,
  output logic [22:0]       wb_lfsr
);
  upd_ctrl_t         ctrl_q;
  logic [WORD_W-1:0] word_q, word_calc, word_adv, start_word, wb_word_q;
  logic [LFSR_W-1:0] lfsr_q, lfsr_nx, lfsr_adv;
  logic              due;

  upd_rate_ctr #(.RATE_W(RATE_W)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (seq_start),
    .fire  (cmd_fire),
    .rate  (ctrl_q.rate),
    .due   (due)
  );

  upd_lfsr_step #(.W(LFSR_W), .TAP(LFSR_TAP)) u_lfsr (
    .state (lfsr_q),
    .next  (lfsr_nx)
  );

  upd_addr_calc u_calc (
    .word    (word_q),
    .ctrl    (ctrl_q),
    .lfsr_nx (lfsr_nx),
    .word_nx (word_calc)
  );

  always_comb begin
    start_word                       = '0;
    start_word[0 +: ROW_W]           = start_row;
    start_word[BANK_LSB +: BANK_W]   = start_bank;
    start_word[RANK_LSB +: RANK_W]   = start_rank;
    word_adv = due ? word_calc : word_q;
    lfsr_adv = (due && ctrl_q.lmode[1]) ? lfsr_nx : lfsr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lfsr_q <= '0;
      ctrl_q <= '0;
    end else if (seq_start) begin
      word_q <= start_word;
      lfsr_q <= start_lfsr;
      ctrl_q <= upd_ctrl_t'(upd_ctrl);
    end else begin
      word_q <= word_adv;
      lfsr_q <= lfsr_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_word_q <= '0;
      wb_lfsr   <= '0;
    end else begin
      wb_valid <= seq_end;
      if (seq_end) begin
        wb_word_q <= word_adv;
        wb_lfsr   <= lfsr_adv;
      end
    end
  end

  assign cur_row  = word_q[0 +: ROW_W];
  assign cur_bank = word_q[BANK_LSB +: BANK_W];
  assign cur_rank = word_q[RANK_LSB +: RANK_W];
  assign wb_row   = wb_word_q[0 +: ROW_W];
  assign wb_bank  = wb_word_q[BANK_LSB +: BANK_W];
  assign wb_rank  = wb_word_q[RANK_LSB +: RANK_W];
endmodule

// File: rtl/addr_autoupd_chk.sv
module addr_autoupd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        seq_start,
  input logic [15:0] start_row,
  input logic [2:0]  start_bank,
  input logic [1:0]  start_rank,
  input logic        cmd_fire,
  input logic        seq_end,
  input logic [15:0] cur_row,
  input logic [2:0]  cur_bank,
  input logic [1:0]  cur_rank,
  input logic        wb_valid,
  input logic [15:0] wb_row,
  input logic [22:0] lfsr_q
);
  a_r1_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> (cur_row == $past(start_row)) && (cur_bank == $past(start_bank))
                  && (cur_rank == $past(start_rank)));

  a_r2_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_fire && !seq_start) |=> $stable(cur_row) && $stable(cur_bank) && $stable(cur_rank));

  a_r7_lfsr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_fire && !seq_start) |=> $stable(lfsr_q));

  a_r8_wb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> wb_valid);

  a_r8_wb_only_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_end |=> !wb_valid);

  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_end |=> $stable(wb_row));
endmodule

bind addr_autoupd addr_autoupd_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .seq_start  (seq_start),
  .start_row  (start_row),
  .start_bank (start_bank),
  .start_rank (start_rank),
  .cmd_fire   (cmd_fire),
  .seq_end    (seq_end),
  .cur_row    (cur_row),
  .cur_bank   (cur_bank),
  .cur_rank   (cur_rank),
  .wb_valid   (wb_valid),
  .wb_row     (wb_row),
  .lfsr_q     (lfsr_q)
);

// File: tb/addr_autoupd_tb.sv
module addr_autoupd_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seq_start = 1'b0;
  logic [15:0] start_row = '0;
  logic [2:0]  start_bank = '0;
  logic [1:0]  start_rank = '0;
  logic [22:0] start_lfsr = '0;
  logic [15:0] upd_ctrl = '0;
  logic        cmd_fire = 1'b0;
  logic        seq_end = 1'b0;
  logic [15:0] cur_row, wb_row;
  logic [2:0]  cur_bank, wb_bank;
  logic [1:0]  cur_rank, wb_rank;
  logic        wb_valid;
  logic [22:0] wb_lfsr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_autoupd u_dut (
    .clk(clk), .rst_n(rst_n), .seq_start(seq_start), .start_row(start_row),
    .start_bank(start_bank), .start_rank(start_rank), .start_lfsr(start_lfsr),
    .upd_ctrl(upd_ctrl), .cmd_fire(cmd_fire), .seq_end(seq_end),
    .cur_row(cur_row), .cur_bank(cur_bank), .cur_rank(cur_rank),
    .wb_valid(wb_valid), .wb_row(wb_row), .wb_bank(wb_bank),
    .wb_rank(wb_rank), .wb_lfsr(wb_lfsr)
  );

  function automatic logic [22:0] lfsr_step(input logic [22:0] s);
    return {s[21:0], s[22] ^ s[17]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_addr(input string req, input logic [15:0] r, input logic [2:0] b,
                            input logic [1:0] k);
    check({req, " row"}, 32'(cur_row), 32'(r));
    check({req, " bank"}, 32'(cur_bank), 32'(b));
    check({req, " rank"}, 32'(cur_rank), 32'(k));
  endtask

  task automatic do_start(input logic [15:0] r, input logic [2:0] b, input logic [1:0] k,
                          input logic [22:0] seed, input logic [15:0] ctl);
    @(negedge clk);
    seq_start = 1'b1; start_row = r; start_bank = b; start_rank = k;
    start_lfsr = seed; upd_ctrl = ctl;
    @(negedge clk);
    seq_start = 1'b0;
  endtask

  task automatic fire();
    @(negedge clk); cmd_fire = 1'b1;
    @(negedge clk); cmd_fire = 1'b0;
  endtask

  task automatic end_seq();
    @(negedge clk); seq_end = 1'b1;
    @(negedge clk); seq_end = 1'b0;
  endtask

  task automatic t_reset();
    check_addr("R10 reset", 16'h0, 3'd0, 2'd0);
    check("R10 wb_valid", 32'(wb_valid), 0);
  endtask

  task automatic t_incr();
    // R3: +1 row, wrap 31, rate 0
    do_start(16'hFFFE, 3'd5, 2'd2, 23'h0, 16'h03E1);
    check_addr("R1 load", 16'hFFFE, 3'd5, 2'd2);
    fire(); check_addr("R3 row+1", 16'hFFFF, 3'd5, 2'd2);
    fire(); check_addr("R3 row field wrap no carry", 16'h0000, 3'd5, 2'd2);
    // R3: +9 row, +1 bank, +3 rank
    do_start(16'h0010, 3'd7, 2'd1, 23'h0, 16'h03FF);
    fire(); check_addr("R3 all fields", 16'h0019, 3'd0, 2'd0);
  endtask

  task automatic t_wrap();
    // R4: window 3..0, +9 row
    do_start(16'h1234, 3'd0, 2'd0, 23'h0, 16'h0063);
    fire(); check_addr("R4 wrap3 first", 16'h123D, 3'd0, 2'd0);
    fire(); check_addr("R4 wrap3 second", 16'h1236, 3'd0, 2'd0);
    // R4: window 21..0 cuts bank; rank outside window
    do_start(16'hABCD, 3'd3, 2'd1, 23'h0, 16'h02AC);
    fire(); check_addr("R4 wrap21 bank cut", 16'hABCD, 3'd0, 2'd1);
    // R4: window 0..0
    do_start(16'h00F0, 3'd0, 2'd0, 23'h0, 16'h0001);
    fire(); check_addr("R4 wrap0 a", 16'h00F1, 3'd0, 2'd0);
    fire(); check_addr("R4 wrap0 b", 16'h00F0, 3'd0, 2'd0);
  endtask

  task automatic t_rate();
    // R2: N=2, update every third command
    do_start(16'h0000, 3'd0, 2'd0, 23'h0, 16'h23E1);
    fire(); check("R2 cmd1", 32'(cur_row), 32'h0);
    fire(); check("R2 cmd2", 32'(cur_row), 32'h0);
    fire(); check("R2 cmd3", 32'(cur_row), 32'h1);
    fire(); fire(); check("R2 cmd5", 32'(cur_row), 32'h1);
    fire(); check("R2 cmd6", 32'(cur_row), 32'h2);
  endtask

  task automatic t_restart();
    // R1: a start clears the partial command count (N=3)
    do_start(16'h0100, 3'd0, 2'd0, 23'h0, 16'h33E1);
    fire(); fire(); check("R2 partial", 32'(cur_row), 32'h100);
    do_start(16'h0200, 3'd0, 2'd0, 23'h0, 16'h33E1);
    fire(); fire(); fire(); check("R1 count cleared", 32'(cur_row), 32'h200);
    fire(); check("R1 fourth after restart", 32'(cur_row), 32'h201);
  endtask

  task automatic t_lfsr_full();
    logic [22:0] s1, s2;
    s1 = lfsr_step(23'h400001);
    s2 = lfsr_step(s1);
    // R5: mode 10, wrap 7, inc bit set but ignored
    do_start(16'h5500, 3'd2, 2'd1, 23'h400001, 16'h08E1);
    fire(); check_addr("R5 step1", 16'h5500 ^ {8'h0, s1[7:0]}, 3'd2, 2'd1);
    check("R5 hand value", 32'(cur_row), 32'h5503);
    fire(); check_addr("R5 step2", 16'h5500 ^ {8'h0, s1[7:0]} ^ {8'h0, s2[7:0]}, 3'd2, 2'd1);
    end_seq();
    check("R8 wb_valid", 32'(wb_valid), 1);
    check("R5 wb_lfsr", 32'(wb_lfsr), 32'(s2));
    check("R8 wb_row", 32'(wb_row), 32'h5505);
    @(negedge clk);
    check("R8 wb_valid one cycle", 32'(wb_valid), 0);
  endtask

  task automatic t_lfsr_skip();
    // R6: mode 11, wrap 7: bits 2..0 untouched
    do_start(16'h0000, 3'd0, 2'd0, 23'h0000FF, 16'h0CE0);
    fire(); check("R6 window 7..3", 32'(cur_row), 32'h00F8);
  endtask

  task automatic t_mode_rsvd();
    // R7: mode 01 increments and keeps state
    do_start(16'h0005, 3'd0, 2'd0, 23'h123456, 16'h07E1);
    fire(); check("R7 increments", 32'(cur_row), 32'h6);
    end_seq();
    check("R7 lfsr unchanged", 32'(wb_lfsr), 32'h123456);
  endtask

  task automatic t_boundary();
    // R9: start, end and command in one cycle
    do_start(16'h0040, 3'd1, 2'd0, 23'h0, 16'h03E1);
    @(negedge clk);
    cmd_fire = 1'b1; seq_end = 1'b1; seq_start = 1'b1; start_row = 16'h0900;
    start_bank = 3'd4; start_rank = 2'd3;
    @(negedge clk);
    cmd_fire = 1'b0; seq_end = 1'b0; seq_start = 1'b0;
    check("R9 wb outgoing row", 32'(wb_row), 32'h41);
    check("R9 wb outgoing bank", 32'(wb_bank), 32'h1);
    check("R8 wb_valid at boundary", 32'(wb_valid), 1);
    check_addr("R9 new start, command ignored", 16'h0900, 3'd4, 2'd3);
    @(negedge clk);
    check("R8 wb pulse ends", 32'(wb_valid), 0);
    check("R8 wb_row held", 32'(wb_row), 32'h41);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_incr();
    t_wrap();
    t_rate();
    t_restart();
    t_lfsr_full();
    t_lfsr_skip();
    t_mode_rsvd();
    t_boundary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule